// File: doc/BRIEF.md
# External Bus Port Multiplexer

This block turns a microcontroller core's external memory requests into pin activity on two 8-bit port groups, called here the low port (P0) and the high port (P2). Each request is a program fetch, a data read or a data write. The block runs it as a fixed sequence of phases. First comes an address phase with an address-latch pulse. Next comes a strobe phase of `STRB_CYC` clocks, which is 2 by default. Last comes a single closing cycle that raises a done pulse and returns the captured read data.

Two bus arrangements are supported. In nonpage mode, data travels on the low port and the high port holds the upper address byte. In page mode, the low port keeps the low address byte for the whole cycle and data travels on the high port. A 2-bit configuration field selects which strobe a data read uses. Every finished cycle also asks the low port's latch register to reload with all ones. The high port latch is never touched, and the high port pins show the latch value whenever they carry neither address nor data.

Top module: `xbus_portmux`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `ale` and `p0_set_ones` are 0, all three strobes are high, `xaddr` is 0, and the port outputs equal `p0_latch` and `p2_latch` with every output enable set.
- R2: A request with `req_valid` high while idle is accepted at that clock edge. It is followed by exactly 1 cycle with `ale` high, then `STRB_CYC` cycles with a strobe low, then 1 cycle with `done` high, then idle. `req_valid` is ignored while `busy` is high.
- R3: During the `ale` cycle the low port drives address bits 7:0. The high port drives address bits 15:8, or `p2_latch` when the width code is 0 (8-bit). Both ports are fully enabled.
- R4: In nonpage mode (`req_page`=0), during the strobe the low port drives the write data for a write or has all enables at 0 for a read. The high port keeps the value it had in the address phase.
- R5: In page mode (`req_page`=1), during the strobe the low port keeps address bits 7:0. The high port drives the write data for a write or has all enables at 0 for a read.
- R6: A fetch strobes `psen_n` and is always a read, whatever `req_write` says. A data write strobes `wr_n`. A data read strobes `psen_n` when `rd_cfg`=2'b00 and `rd_n` for any other value. At most one strobe is low at a time.
- R7: Width codes are 0=8, 1=16, 2=17 and 3=18 address bits. `xaddr[0]` carries address bit 16 when the code is at least 2, and `xaddr[1]` carries bit 17 when the code is 3. Both are driven only in the `ale` and strobe phases and are 0 otherwise. A fetch with code 0 is run as 16-bit.
- R8: `rdata` takes the data port's input (`p0_in` in nonpage mode, `p2_in` in page mode) at the clock edge that ends the strobe. It is valid while `done` is high and holds until the next capture.
- R9: `p0_set_ones` is high exactly in the `done` cycle of every bus cycle, so the low port latch becomes 0xFF. No output ever requests a change to the high port latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Start a bus cycle (taken only when idle) |
| req_addr | input | 18 | Request address |
| req_wdata | input | 8 | Write data |
| req_write | input | 1 | 1 = write, 0 = read |
| req_fetch | input | 1 | 1 = program fetch |
| req_width | input | 2 | Address width code |
| req_page | input | 1 | 1 = page mode |
| rd_cfg | input | 2 | Data-read strobe select |
| p0_latch | input | 8 | Low port latch register value |
| p2_latch | input | 8 | High port latch register value |
| p0_in | input | 8 | Low port pin input |
| p2_in | input | 8 | High port pin input |
| p0_out | output | 8 | Low port drive value |
| p0_oe | output | 8 | Low port per-pin output enable |
| p2_out | output | 8 | High port drive value |
| p2_oe | output | 8 | High port per-pin output enable |
| xaddr | output | 2 | Extra address lines for bits 16 and 17 |
| ale | output | 1 | Address latch enable |
| psen_n | output | 1 | Program store strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| busy | output | 1 | Bus cycle in progress |
| done | output | 1 | Last cycle of a bus cycle |
| rdata | output | 8 | Captured read data |
| p0_set_ones | output | 1 | Request to load 0xFF into the low port latch |

## Verification
The bench builds the block with the default two-clock strobe and the fixed 8-bit ports and 18-bit address. This lets it check the pins phase by phase for each combination of mode, direction, width code and read-strobe setting. It keeps its own copy of the low port latch and updates it from `p0_set_ones`. With that copy it can see the all-ones overwrite on the idle pins and confirm that the high port keeps its latch value. For every read, it drives different bytes onto the two port inputs, which shows that the capture came from the right port.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
    localparam int XB_PW = 8;
    localparam int XB_AW = 18;
    localparam int XB_XN = XB_AW - 16;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ALE  = 2'd1,
        PH_STRB = 2'd2,
        PH_END  = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        AW_8  = 2'd0,
        AW_16 = 2'd1,
        AW_17 = 2'd2,
        AW_18 = 2'd3
    } awidth_e;

    typedef struct packed {
        logic [XB_AW-1:0] addr;
        logic [XB_PW-1:0] wdata;
        logic             write;
        logic             fetch;
        awidth_e          width;
        logic             page;
        logic [1:0]       rd_cfg;
    } xreq_t;
endpackage

// File: rtl/xbus_seq.sv
module xbus_seq
    import xbus_pkg::*;
#(
    parameter int STRB_CYC = 2
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    input  xreq_t  req_in,
    output phase_e phase,
    output xreq_t  req_q,
    output logic   cap_en,
    output logic   busy
);
    localparam int CW   = (STRB_CYC < 2) ? 1 : $clog2(STRB_CYC);
    localparam int LAST = STRB_CYC - 1;

    typedef struct packed {
        phase_e        phase;
        logic [CW-1:0] cnt;
        xreq_t         req;
    } seq_t;

    seq_t st_d, st_q;
    xreq_t norm;

    always_comb begin
        norm = req_in;
        if (req_in.fetch) begin
            norm.write = 1'b0;
            if (req_in.width == AW_8) begin
                norm.width = AW_16;
            end
        end
    end

    always_comb begin
        st_d = st_q;
        case (st_q.phase)
            PH_IDLE: begin
                if (start) begin
                    st_d.phase = PH_ALE;
                    st_d.req   = norm;
                    st_d.cnt   = '0;
                end
            end
            PH_ALE: begin
                st_d.phase = PH_STRB;
                st_d.cnt   = '0;
            end
            PH_STRB: begin
                if (st_q.cnt == CW'(LAST)) begin
                    st_d.phase = PH_END;
                end else begin
                    st_d.cnt = st_q.cnt + CW'(1);
                end
            end
            default: begin
                st_d.phase = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase  = st_q.phase;
    assign req_q  = st_q.req;
    assign cap_en = (st_q.phase == PH_STRB) && (st_q.cnt == CW'(LAST));
    assign busy   = (st_q.phase != PH_IDLE);

    // R2: a new request arriving during a cycle does not alter the held request
    assert_busy_ignores_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(req_q));
endmodule

// File: rtl/xbus_route.sv
module xbus_route
    import xbus_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  phase_e           phase,
    input  xreq_t            req,
    input  logic [XB_PW-1:0] p0_latch,
    input  logic [XB_PW-1:0] p2_latch,
    output logic [XB_PW-1:0] p0_out,
    output logic [XB_PW-1:0] p0_oe,
    output logic [XB_PW-1:0] p2_out,
    output logic [XB_PW-1:0] p2_oe,
    output logic [XB_XN-1:0] xaddr,
    output logic             ale,
    output logic             psen_n,
    output logic             rd_n,
    output logic             wr_n
);
    localparam logic [XB_PW-1:0] ALL_ON  = {XB_PW{1'b1}};
    localparam logic [XB_PW-1:0] ALL_OFF = {XB_PW{1'b0}};

    logic             active;
    logic             strb;
    logic [XB_PW-1:0] hi_byte;
    logic [XB_PW-1:0] lo_byte;
    logic [2:0]       wcode;

    assign active  = (phase == PH_ALE) || (phase == PH_STRB);
    assign strb    = (phase == PH_STRB);
    assign lo_byte = req.addr[XB_PW-1:0];
    assign hi_byte = (req.width == AW_8) ? p2_latch : req.addr[2*XB_PW-1:XB_PW];
    assign wcode   = {1'b0, req.width};

    for (genvar gi = 0; gi < XB_XN; gi++) begin : g_xaddr
        assign xaddr[gi] = active && (wcode >= 3'(gi + 2)) && req.addr[16+gi];
    end

    always_comb begin
        p0_out = p0_latch;
        p0_oe  = ALL_ON;
        p2_out = p2_latch;
        p2_oe  = ALL_ON;
        if (phase == PH_ALE) begin
            p0_out = lo_byte;
            p2_out = hi_byte;
        end else if (strb) begin
            if (req.page) begin
                p0_out = lo_byte;
                p2_out = req.write ? req.wdata : p2_latch;
                p2_oe  = req.write ? ALL_ON : ALL_OFF;
            end else begin
                p2_out = hi_byte;
                p0_out = req.write ? req.wdata : p0_latch;
                p0_oe  = req.write ? ALL_ON : ALL_OFF;
            end
        end
    end

    always_comb begin
        ale    = (phase == PH_ALE);
        psen_n = 1'b1;
        rd_n   = 1'b1;
        wr_n   = 1'b1;
        if (strb) begin
            if (req.fetch) begin
                psen_n = 1'b0;
            end else if (req.write) begin
                wr_n = 1'b0;
            end else if (req.rd_cfg == 2'b00) begin
                psen_n = 1'b0;
            end else begin
                rd_n = 1'b0;
            end
        end
    end

    // R4: nonpage reads float the low port while the read strobe is low
    assert_lo_port_float_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n && !req.page) |-> (p0_oe == ALL_OFF));
    // R5: page-mode reads float the high port while a read strobe is low
    assert_hi_port_float_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((!rd_n || !psen_n) && req.page) |-> (p2_oe == ALL_OFF));
    // R7: extra address lines are quiet outside address and strobe phases
    assert_xaddr_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ale == 1'b0 && psen_n && rd_n && wr_n) |-> (xaddr == '0));
endmodule

// File: rtl/xbus_portmux.sv
module xbus_portmux
    import xbus_pkg::*;
#(
    parameter int STRB_CYC = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         req_valid,
    input  logic [17:0]  req_addr,
    input  logic [7:0]   req_wdata,
    input  logic         req_write,
    input  logic         req_fetch,
    input  logic [1:0]   req_width,
    input  logic         req_page,
    input  logic [1:0]   rd_cfg,
    input  logic [7:0]   p0_latch,
    input  logic [7:0]   p2_latch,
    input  logic [7:0]   p0_in,
    input  logic [7:0]   p2_in,
    output logic [7:0]   p0_out,
    output logic [7:0]   p0_oe,
    output logic [7:0]   p2_out,
    output logic [7:0]   p2_oe,
    output logic [1:0]   xaddr,
    output logic         ale,
    output logic         psen_n,
    output logic         rd_n,
    output logic         wr_n,
    output logic         busy,
    output logic         done,
    output logic [7:0]   rdata,
    output logic         p0_set_ones
);
    phase_e phase;
    xreq_t  req_in;
    xreq_t  req_q;
    logic   cap_en;

    typedef struct packed {
        logic [XB_PW-1:0] rdata;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        req_in.addr   = req_addr;
        req_in.wdata  = req_wdata;
        req_in.write  = req_write;
        req_in.fetch  = req_fetch;
        req_in.width  = awidth_e'(req_width);
        req_in.page   = req_page;
        req_in.rd_cfg = rd_cfg;
    end

    xbus_seq #(.STRB_CYC(STRB_CYC)) i_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (req_valid),
        .req_in (req_in),
        .phase  (phase),
        .req_q  (req_q),
        .cap_en (cap_en),
        .busy   (busy)
    );

    xbus_route i_route (
        .clk      (clk),
        .rst_n    (rst_n),
        .phase    (phase),
        .req      (req_q),
        .p0_latch (p0_latch),
        .p2_latch (p2_latch),
        .p0_out   (p0_out),
        .p0_oe    (p0_oe),
        .p2_out   (p2_out),
        .p2_oe    (p2_oe),
        .xaddr    (xaddr),
        .ale      (ale),
        .psen_n   (psen_n),
        .rd_n     (rd_n),
        .wr_n     (wr_n)
    );

    always_comb begin
        cap_d = cap_q;
        if (cap_en) begin
            cap_d.rdata = req_q.page ? p2_in : p0_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign rdata       = cap_q.rdata;
    assign done        = (phase == PH_END);
    assign p0_set_ones = done;

    // R6: strobes never overlap
    assert_one_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({~psen_n, ~rd_n, ~wr_n}) <= 1);
    // R2: the address pulse is followed by an active strobe
    assert_ale_then_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> (!psen_n || !rd_n || !wr_n));
    // R2: the done cycle returns the block to idle
    assert_done_then_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
    // R9: latch overwrite request only in the closing cycle
    assert_ones_in_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        p0_set_ones |-> (done && psen_n && rd_n && wr_n));
    // R8: captured data holds after it is presented
    assert_rdata_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> $stable(rdata));
endmodule

// File: tb/test_xbus_portmux.sv
`timescale 1ns/1ps
module test_xbus_portmux;
    localparam int STRB = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [17:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_write = 1'b0;
    logic        req_fetch = 1'b0;
    logic [1:0]  req_width = '0;
    logic        req_page = 1'b0;
    logic [1:0]  rd_cfg = '0;
    logic [7:0]  p0_latch = 8'h5A;
    logic [7:0]  p2_latch = 8'hC3;
    logic [7:0]  p0_in = '0;
    logic [7:0]  p2_in = '0;
    logic [7:0]  p0_out, p0_oe, p2_out, p2_oe, rdata;
    logic [1:0]  xaddr;
    logic        ale, psen_n, rd_n, wr_n, busy, done, p0_set_ones;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    typedef struct { bit is_read; logic [7:0] data; } exp_t;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    xbus_portmux #(.STRB_CYC(STRB)) i_xbus_portmux (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_write(req_write), .req_fetch(req_fetch),
        .req_width(req_width), .req_page(req_page), .rd_cfg(rd_cfg),
        .p0_latch(p0_latch), .p2_latch(p2_latch), .p0_in(p0_in), .p2_in(p2_in),
        .p0_out(p0_out), .p0_oe(p0_oe), .p2_out(p2_out), .p2_oe(p2_oe),
        .xaddr(xaddr), .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
        .busy(busy), .done(done), .rdata(rdata), .p0_set_ones(p0_set_ones)
    );

    // bench-side low port latch register, reloaded on request
    always @(posedge clk) if (p0_set_ones) p0_latch <= 8'hFF;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic chk_idle(input string req);
        chk(!busy && !done && !ale, req, "idle ctrl", {busy, done, ale}, 0);
        chk({psen_n, rd_n, wr_n} == 3'b111, req, "idle strobes", {psen_n, rd_n, wr_n}, 3'b111);
        chk(xaddr == 2'b00, req, "idle xaddr", xaddr, 0);
        chk(p0_out == p0_latch && p2_out == p2_latch, req, "idle ports",
            {p0_out, p2_out}, {p0_latch, p2_latch});
        chk(p0_oe == 8'hFF && p2_oe == 8'hFF, req, "idle oe", {p0_oe, p2_oe}, 16'hFFFF);
    endtask

    // monitor: pop expected item on every done cycle
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R2", "unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(p0_set_ones, "R9", "ones request in done", p0_set_ones, 1);
                if (e.is_read) chk(rdata == e.data, "R8", "rdata", rdata, e.data);
            end
        end
    end

    task automatic run(input logic [17:0] a, input logic [7:0] wd, input bit wr,
                       input bit fe, input logic [1:0] w, input bit pg,
                       input logic [1:0] rc, input logic [7:0] din, input bit poke);
        bit ewr;
        logic [1:0] ew;
        logic [7:0] hi;
        logic [2:0] es;
        logic [1:0] ex;
        exp_t e;
        ewr = wr && !fe;
        ew  = (fe && w == 2'd0) ? 2'd1 : w;
        hi  = (ew == 2'd0) ? p2_latch : a[15:8];
        es  = fe ? 3'b011 : (ewr ? 3'b110 : (rc == 2'b00 ? 3'b011 : 3'b101));
        ex  = {(ew == 2'd3) & a[17], (ew >= 2'd2) & a[16]};
        e.is_read = !ewr;
        e.data = din;
        sb.push_back(e);
        p0_in = pg ? ~din : din;
        p2_in = pg ? din : ~din;
        req_addr = a; req_wdata = wd; req_write = wr; req_fetch = fe;
        req_width = w; req_page = pg; rd_cfg = rc; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        // address phase
        chk(ale && busy, "R2", "ale phase", {ale, busy}, 2'b11);
        chk(p0_out == a[7:0] && p0_oe == 8'hFF, "R3", "lo addr", p0_out, a[7:0]);
        chk(p2_out == hi && p2_oe == 8'hFF, "R3", "hi addr", p2_out, hi);
        chk(xaddr == ex, "R7", "xaddr in ale", xaddr, ex);
        for (int k = 0; k < STRB; k++) begin
            @(negedge clk);
            if (poke && k == 0) begin
                req_valid = 1'b1; req_addr = ~a; req_page = ~pg;
            end
            chk(!ale && {psen_n, rd_n, wr_n} == es, "R6", "strobe", {psen_n, rd_n, wr_n}, es);
            chk(xaddr == ex, "R7", "xaddr in strobe", xaddr, ex);
            if (!pg) begin
                chk(p2_out == hi && p2_oe == 8'hFF, "R4", "hi held", p2_out, hi);
                if (ewr) chk(p0_out == wd && p0_oe == 8'hFF, "R4", "lo wdata", p0_out, wd);
                else     chk(p0_oe == 8'h00, "R4", "lo float", p0_oe, 0);
            end else begin
                chk(p0_out == a[7:0] && p0_oe == 8'hFF, "R5", "lo held", p0_out, a[7:0]);
                if (ewr) chk(p2_out == wd && p2_oe == 8'hFF, "R5", "hi wdata", p2_out, wd);
                else     chk(p2_oe == 8'h00, "R5", "hi float", p2_oe, 0);
            end
        end
        req_valid = 1'b0;
        @(negedge clk);
        chk(done && {psen_n, rd_n, wr_n} == 3'b111 && xaddr == 2'b00, "R2", "done cycle",
            {done, psen_n, rd_n, wr_n, xaddr}, 6'b111100);
        p0_in = 8'h00; p2_in = 8'h00;
        @(negedge clk);
        chk(p0_latch == 8'hFF, "R9", "lo latch all ones", p0_latch, 8'hFF);
        chk_idle("R2");
    endtask

    initial begin
        #(5.0 * 200000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk_idle("R1");
        chk(!p0_set_ones && rdata == 8'h00, "R1", "reset outputs", {p0_set_ones, rdata}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_idle("R1");
        // R4 nonpage write 16-bit
        run(18'h0_12_34, 8'hA5, 1, 0, 2'd1, 0, 2'b01, 8'h00, 0);
        p0_latch = 8'h33;
        // R4 R6 nonpage data read, rd strobe
        run(18'h3_AB_CD, 8'h00, 0, 0, 2'd1, 0, 2'b01, 8'h6E, 0);
        // R3 8-bit read, high port shows latch, psen strobe
        p2_latch = 8'h7B;
        run(18'h3_FF_42, 8'h00, 0, 0, 2'd0, 0, 2'b00, 8'h19, 0);
        // R5 R7 page write 17-bit
        run(18'h3_56_78, 8'h3C, 1, 0, 2'd2, 1, 2'b10, 8'h00, 0);
        // R5 R7 R8 page read 18-bit rd strobe
        run(18'h2_9A_BC, 8'h00, 0, 0, 2'd3, 1, 2'b11, 8'hD2, 0);
        // R6 R7 fetch with write flag and 8-bit code: 16-bit read on psen
        run(18'h1_24_68, 8'hEE, 1, 1, 2'd0, 0, 2'b01, 8'h81, 0);
        // R6 R7 fetch 18-bit page
        run(18'h3_0F_F0, 8'h00, 0, 1, 2'd3, 1, 2'b11, 8'h4B, 0);
        // R2 request while busy is ignored
        run(18'h0_55_AA, 8'h00, 0, 0, 2'd1, 0, 2'b01, 8'h2D, 1);
        @(negedge clk);
        chk(!busy && !ale, "R2", "no start from busy request", {busy, ale}, 0);
        chk(sb.size() == 0, "R2", "scoreboard drained", sb.size(), 0);
        chk(p2_out == p2_latch, "R9", "hi latch unchanged on pins", p2_out, p2_latch);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule